// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

A combinational adder of parameterized width (16 bits by default; the width must be a power of two). It adds two operands and a carry input, and returns the sum and a carry output. Every column first forms a generate term (both operand bits set) and a propagate term (either operand bit set). A tree of prefix cells then combines these terms, doubling the covered span at each level, so the carry into every column is known after log2(W) levels.

The carry input enters the tree as an extra column placed below bit 0. That column generates the carry input and never propagates, so no separate carry path is needed. Each sum bit is the exclusive OR of its two operand bits and the prefix generate of all columns below it. The carry output is one more combine of the top column with the prefix generate below it. The block has no registers, and its outputs follow its inputs within the same time step.

Top module: `prefix_adder`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^W for every operand pair and either carry input.
- R2: `cout` equals bit W of the (W+1)-bit result a + b + cin.
- R3: With a = 0 and b = 0, `sum` equals cin in bit 0 with all other bits zero, and `cout` is 0. The carry input therefore acts only as a generate below bit 0 and never propagates.
- R4: When every column propagates without generating (a XOR b all ones, a AND b zero), a carry input of 0 gives `sum` all ones and `cout` 0. A carry input of 1 ripples through every column and gives `sum` all zeros and `cout` 1.
- R5: When both operand bits of the top column are 1, `cout` is 1 whatever the lower bits and the carry input.
- R6: R1 and R2 hold at widths 8, 16 and 32 for the same parameterized design.
- R7: The outputs are purely combinational. A new input value is reflected at the outputs in the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry input, treated as the column below bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of the top column |

## Verification
The embedded checks are combinational and take for granted that `a`, `b` and `cin` carry known 0/1 values when they are evaluated. They stay silent while any input is unknown. The bench settles every input to a known value before it samples, and it changes the inputs only half a period away from the sampling point. The checks also assume a power-of-two width. The bench instantiates only 8, 16 and 32.

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LV = $clog2(W);

  // index x holds column x-1; index 0 is the carry-input column
  logic [W-1:0]          gc, pc;
  logic [LV:0][W-1:0]    g;
  logic [LV-1:0][W-1:0]  p;

  if (W > 1) begin : g_cols
    assign gc = {a[W-2:0] & b[W-2:0], cin};
    assign pc = {a[W-2:0] | b[W-2:0], 1'b0};
  end else begin : g_cols1
    assign gc = cin;
    assign pc = 1'b0;
  end

  assign g[0] = gc;
  assign p[0] = pc;

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    for (genvar x = 0; x < W; x++) begin : g_cell
      if (x >= D) begin : g_blk
        assign g[lv+1][x] = g[lv][x] | (p[lv][x] & g[lv][x-D]);
        if (lv < LV - 1) begin : g_pp
          assign p[lv+1][x] = p[lv][x] & p[lv][x-D];
        end
      end else begin : g_pass
        assign g[lv+1][x] = g[lv][x];
        if (lv < LV - 1) begin : g_pp
          assign p[lv+1][x] = p[lv][x];
        end
      end
    end
  end

  assign sum  = a ^ b ^ g[LV];
  assign cout = (a[W-1] & b[W-1]) | ((a[W-1] | b[W-1]) & g[LV][W-1]);

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_total_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("R1/R2 sum mismatch");
      p_top_gen_r5: assert (!(a[W-1] && b[W-1]) || cout)
        else $error("R5 top generate lost");
      p_cin_only_r3: assert (!(a == '0 && b == '0) || ({cout, sum} == {{W{1'b0}}, cin}))
        else $error("R3 carry input misplaced");
      p_ripple_r4: assert (!(((a ^ b) == '1) && ((a & b) == '0)) ||
                           (cout == cin && sum == {W{~cin}}))
        else $error("R4 full propagate wrong");
      p_anchor_noprop_r3: assert (p[LV-1][W/2-1:0] == '0)
        else $error("R3 span through carry column propagates");
    end
  end
endmodule

// File: tb/prefix_adder_tb.sv
module prefix_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  a8, b8, s8;
  logic [15:0] a16, b16, s16;
  logic [31:0] a32, b32, s32;
  logic c8, c16, c32, co8, co16, co32;

  prefix_adder #(.W(8))  u_dut8  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
  prefix_adder #(.W(16)) u_dut   (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  prefix_adder #(.W(32)) u_dut32 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

  logic [8:0]  q8[$];
  logic [16:0] q16[$];
  logic [32:0] q32[$];
  string qts[$];
  string qtc[$];

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic drive(input logic [7:0] xa8, input logic [7:0] xb8, input logic xc8,
                       input logic [15:0] xa16, input logic [15:0] xb16, input logic xc16,
                       input logic [31:0] xa32, input logic [31:0] xb32, input logic xc32,
                       input string ts, input string tc);
    @(posedge clk);
    #1;
    a8 = xa8;   b8 = xb8;   c8 = xc8;
    a16 = xa16; b16 = xb16; c16 = xc16;
    a32 = xa32; b32 = xb32; c32 = xc32;
    q8.push_back({1'b0, xa8} + {1'b0, xb8} + {8'd0, xc8});
    q16.push_back({1'b0, xa16} + {1'b0, xb16} + {16'd0, xc16});
    q32.push_back({1'b0, xa32} + {1'b0, xb32} + {32'd0, xc32});
    qts.push_back(ts);
    qtc.push_back(tc);
  endtask

  task automatic same(input logic [31:0] xa, input logic [31:0] xb, input logic xc,
                      input string ts, input string tc);
    drive(xa[7:0], xb[7:0], xc, xa[15:0], xb[15:0], xc, xa, xb, xc, ts, tc);
  endtask

  // monitor: pops one expected item per cycle, half a period after the drive
  always @(negedge clk) begin
    if (!rst && q8.size() > 0) begin
      logic [8:0]  e8;
      logic [16:0] e16;
      logic [32:0] e32;
      string ts, tc;
      e8 = q8.pop_front(); e16 = q16.pop_front(); e32 = q32.pop_front();
      ts = qts.pop_front(); tc = qtc.pop_front();
      checks += 6;
      if (s8 !== e8[7:0]) begin
        failures++; $display("FAIL %s w8 sum got %h exp %h", ts, s8, e8[7:0]);
      end
      if (co8 !== e8[8]) begin
        failures++; $display("FAIL %s w8 cout got %b exp %b", tc, co8, e8[8]);
      end
      if (s16 !== e16[15:0]) begin
        failures++; $display("FAIL %s w16 sum got %h exp %h", ts, s16, e16[15:0]);
      end
      if (co16 !== e16[16]) begin
        failures++; $display("FAIL %s w16 cout got %b exp %b", tc, co16, e16[16]);
      end
      if (s32 !== e32[31:0]) begin
        failures++; $display("FAIL %s w32 sum got %h exp %h", ts, s32, e32[31:0]);
      end
      if (co32 !== e32[32]) begin
        failures++; $display("FAIL %s w32 cout got %b exp %b", tc, co32, e32[32]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired got %0d cycles exp <= %0d", cycles, MAX_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R7: zero inputs give zero outputs in the same step, checked without any clock
    #2;
    checks++;
    if ({co16, s16} !== 17'd0) begin
      failures++; $display("FAIL R7 idle got %h exp 0", {co16, s16});
    end
    a16 = 16'h1234; b16 = 16'h4321; c16 = 1'b1;
    #1;
    checks++;
    if ({co16, s16} !== 17'h05556) begin
      failures++; $display("FAIL R7 same-step got %h exp 05556", {co16, s16});
    end

    // R3: carry input alone
    same(32'h0, 32'h0, 1'b0, "R3", "R3");
    same(32'h0, 32'h0, 1'b1, "R3", "R3");
    // R4: full propagate, both carry inputs
    same(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R4", "R4");
    same(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R4", "R4");
    same(32'hFFFF_FFFF, 32'h0, 1'b1, "R4", "R4");
    // R5: top-column generate at each width
    drive(8'h80, 8'h80, 1'b0, 16'h8000, 16'h8000, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R1", "R5");
    drive(8'hC3, 8'h9A, 1'b1, 16'hF00F, 16'h8123, 1'b0, 32'hFFFF_0001, 32'h8000_FFFF, 1'b1, "R1", "R5");
    // R1/R2: all ones plus all ones plus one
    same(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1", "R2");
    same(32'h0F0F_0F0F, 32'h0101_0101, 1'b0, "R1", "R2");

    // R1 R2 exhaustive at 8 bits, R6 random at 16 and 32 bits
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        for (int ic = 0; ic < 2; ic++) begin
          drive(ia[7:0], ib[7:0], ic[0],
                16'($urandom), 16'($urandom), 1'($urandom),
                $urandom, $urandom, 1'($urandom),
                "R1 R6", "R2 R6");
        end
      end
    end

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule